// File: doc/BRIEF.md
# Power-Mode-Aware Watchdog Timer

This block is a watchdog counter that advances on a slow tick enable. A small prescaler first divides the tick into base periods. A postscaler then multiplies that period by a power of two, and the exponent comes from a static configuration input. Once software turns the watchdog on, it must keep servicing it. If the count runs out, the block takes one of two actions, chosen by the power state sampled at that moment. With the core awake, it emits a one-cycle device-reset pulse. With the core in sleep or idle, it emits a one-cycle non-maskable wake pulse instead and leaves every register of the block untouched.

Sticky status flags record that a time-out happened and whether the core was sleeping or idle at the time, so start-up code can tell the cases apart. Software reaches the block through one register write port. Each write carries an operation code: plain write, set alias or clear alias. The register contents can be read back in parallel at all times. The chip-level reset (`sys_rst_i`) clears the enable but keeps the status flags. Only the power-on reset clears everything.

Top module: `wdog_pm_top`

## Requirements
- R1: An expiry while `in_sleep` and `in_idle` are both 0 drives `rst_o` high for exactly one cycle. The expiry falls on the BASE_TICKS × 2^e-th tick enable counted after the enabling or servicing write. The count then restarts from zero, so the next expiry follows after another full period.
- R2: An expiry while `in_sleep` or `in_idle` is 1 drives `nmi_o` high for exactly one cycle and leaves `rst_o` low. The enable bit and all other register state are left as they were.
- R3: Every expiry sets the time-out flag, read at `rd_data[4]`. In the same cycle, the sleep flag `rd_data[3]` becomes 1 if `in_sleep` is 1, and the idle flag `rd_data[2]` becomes 1 if `in_idle` is 1. All three flags are sticky.
- R4: The flags are cleared only by a power-on reset, or by a clear-alias write with a 1 in the flag's bit position. Plain writes, set-alias writes and `sys_rst_i` leave them unchanged. If an expiry and a clear land in the same cycle, the expiry wins.
- R5: Bit 15 of the register is the enable. `wr_op` selects the write type: 0 is a plain write, which loads bit 15; 1 is the set alias, which sets bit 15 only if it is written as 1; 2 is the clear alias, which clears bit 15 only if it is written as 1; 3 is ignored.
- R6: A plain or set-alias write with bit 0 = 1 services the watchdog while it is enabled, restarting the prescaler and the count. Bit 0 always reads 0. A service write has no effect while the watchdog is disabled. A service write in the cycle of an expiry cancels the expiry.
- R7: The exponent e is `cfg_post`, clamped to POST_MAX. No register field can change it.
- R8: While the watchdog is disabled, the prescaler and count are held at zero and no pulse is produced. After re-enabling, the first expiry comes after a full period.
- R9: `sys_rst_i` clears the enable and the count on the next edge and takes priority over a write in the same cycle. It leaves the status flags as they were.
- R10: `por_n` low asynchronously clears every register of the block. `rst_o`, `nmi_o` and `rd_data` all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst_i | input | 1 | Synchronous chip-level reset; keeps the status flags |
| tick_en | input | 1 | Slow time-base enable, one cycle per tick |
| cfg_post | input | POST_W | Static postscaler exponent |
| in_sleep | input | 1 | Core is in sleep |
| in_idle | input | 1 | Core is in idle |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 2 | 0 plain, 1 set alias, 2 clear alias, 3 none |
| wr_data | input | REG_W | Write data |
| rd_data | output | REG_W | Register readback: bit 15 enable, bits 4/3/2 flags |
| rst_o | output | 1 | One-cycle device-reset request |
| nmi_o | output | 1 | One-cycle non-maskable wake request |

## Verification
The bench targets a service write that lands in the very cycle the count would expire. A design that let the expiry win there would emit a reset even though software met its deadline. It also checks that time-outs in sleep and in idle keep the enable bit set and raise only `nmi_o`. A block that routed the action by the wrong power state would reset a sleeping chip. The bench drives `sys_rst_i` and plain and set-alias writes while flags are set, which catches flags that clear on the wrong event. Finally, it measures timeout lengths in ticks for a sparse tick pattern and for an exponent above POST_MAX. Off-by-one prescaler or counter terminals, and a missing clamp, show up there as a wrong tick count.

// File: rtl/wdpm_pkg.sv
package wdpm_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } wr_op_e;

  localparam int BIT_EN  = 15;
  localparam int BIT_TMO = 4;
  localparam int BIT_SLP = 3;
  localparam int BIT_IDL = 2;
  localparam int BIT_SVC = 0;

  // Postscale exponent after clamping to the supported maximum.
  function automatic int unsigned post_exp(input int unsigned raw, input int unsigned max_e);
    return (raw > max_e) ? max_e : raw;
  endfunction

  // Number of base periods in one full time-out.
  function automatic int unsigned post_limit(input int unsigned raw, input int unsigned max_e);
    return 32'd1 << post_exp(raw, max_e);
  endfunction

  // Enable bit after a write of the given type.
  function automatic logic next_enable(input logic cur, input wr_op_e op, input logic wbit);
    case (op)
      OP_WRITE: return wbit;
      OP_SET:   return cur | wbit;
      OP_CLEAR: return cur & ~wbit;
      default:  return cur;
    endcase
  endfunction

  function automatic logic core_awake(input logic sleep, input logic idle);
    return !(sleep || idle);
  endfunction

endpackage

// File: rtl/wdpm_ctrl.sv
module wdpm_ctrl
  import wdpm_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rst,
  input  logic       wr_en,
  input  logic [1:0] wr_op,
  input  logic       wbit_en,
  input  logic       wbit_svc,
  input  logic [2:0] wbit_flags,
  output logic       en_o,
  output logic       svc_o,
  output logic [2:0] clr_o
);

  wr_op_e op;
  logic   en_q;
  logic   is_svc_op;

  assign op        = wr_op_e'(wr_op);
  assign is_svc_op = (op == OP_WRITE) || (op == OP_SET);

  always_comb begin
    svc_o = wr_en && is_svc_op && wbit_svc && en_q && !sys_rst;
    clr_o = (wr_en && (op == OP_CLEAR) && !sys_rst) ? wbit_flags : 3'b000;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       en_q <= 1'b0;
    else if (sys_rst) en_q <= 1'b0;
    else if (wr_en)   en_q <= next_enable(en_q, op, wbit_en);
  end

  assign en_o = en_q;

endmodule

// File: rtl/wdpm_count.sv
module wdpm_count
  import wdpm_pkg::*;
#(
  parameter int BASE_TICKS = 4,
  parameter int POST_MAX   = 20,
  parameter int POST_W     = 5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst,
  input  logic              en,
  input  logic              svc,
  input  logic              tick_en,
  input  logic [POST_W-1:0] cfg_post,
  output logic              expire_o
);

  localparam int CNT_W = POST_MAX + 1;

  logic             hold;
  logic             step;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_m1;

  assign hold = sys_rst || !en || svc;

  generate
    if (BASE_TICKS > 1) begin : g_pre
      localparam int PRE_W = $clog2(BASE_TICKS);
      logic [PRE_W-1:0] pre_q;
      assign step = tick_en && (pre_q == PRE_W'(BASE_TICKS - 1));
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       pre_q <= '0;
        else if (hold)    pre_q <= '0;
        else if (step)    pre_q <= '0;
        else if (tick_en) pre_q <= pre_q + 1'b1;
      end
    end else begin : g_nopre
      assign step = tick_en;
    end
  endgenerate

  assign lim_m1   = CNT_W'(post_limit(32'(cfg_post), POST_MAX) - 32'd1);
  assign expire_o = !hold && step && (cnt_q == lim_m1);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        cnt_q <= '0;
    else if (hold)     cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else if (step)     cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/wdpm_action.sv
module wdpm_action
  import wdpm_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       expire,
  input  logic       in_sleep,
  input  logic       in_idle,
  input  logic [2:0] clr,
  output logic       rst_o,
  output logic       nmi_o,
  output logic [2:0] flags_o
);

  logic awake;
  logic rst_q, nmi_q, tmo_q, slp_q, idl_q;

  assign awake = core_awake(in_sleep, in_idle);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_q <= 1'b0;
      nmi_q <= 1'b0;
      tmo_q <= 1'b0;
      slp_q <= 1'b0;
      idl_q <= 1'b0;
    end else begin
      rst_q <= expire && awake;
      nmi_q <= expire && !awake;
      tmo_q <= expire | (tmo_q & ~clr[2]);
      slp_q <= (expire & in_sleep) | (slp_q & ~clr[1]);
      idl_q <= (expire & in_idle) | (idl_q & ~clr[0]);
    end
  end

  assign rst_o   = rst_q;
  assign nmi_o   = nmi_q;
  assign flags_o = {tmo_q, slp_q, idl_q};

endmodule

// File: rtl/wdog_pm_top.sv
module wdog_pm_top
  import wdpm_pkg::*;
#(
  parameter int BASE_TICKS = 4,
  parameter int POST_MAX   = 20,
  parameter int REG_W      = 16,
  localparam int POST_W    = $clog2(POST_MAX + 1)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_i,
  input  logic              tick_en,
  input  logic [POST_W-1:0] cfg_post,
  input  logic              in_sleep,
  input  logic              in_idle,
  input  logic              wr_en,
  input  logic [1:0]        wr_op,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              rst_o,
  output logic              nmi_o
);

  logic       en_w;
  logic       svc_w;
  logic       expire_w;
  logic [2:0] clr_w;
  logic [2:0] flags_w;
  logic       unused_wbits;

  assign unused_wbits = ^{wr_data[REG_W-1:BIT_EN+1], wr_data[BIT_EN-1:BIT_TMO+1],
                          wr_data[BIT_IDL-1:BIT_SVC+1]};

  wdpm_ctrl u_ctrl (
    .clk        (clk),
    .por_n      (por_n),
    .sys_rst    (sys_rst_i),
    .wr_en      (wr_en),
    .wr_op      (wr_op),
    .wbit_en    (wr_data[BIT_EN]),
    .wbit_svc   (wr_data[BIT_SVC]),
    .wbit_flags ({wr_data[BIT_TMO], wr_data[BIT_SLP], wr_data[BIT_IDL]}),
    .en_o       (en_w),
    .svc_o      (svc_w),
    .clr_o      (clr_w)
  );

  wdpm_count #(
    .BASE_TICKS (BASE_TICKS),
    .POST_MAX   (POST_MAX),
    .POST_W     (POST_W)
  ) u_count (
    .clk      (clk),
    .por_n    (por_n),
    .sys_rst  (sys_rst_i),
    .en       (en_w),
    .svc      (svc_w),
    .tick_en  (tick_en),
    .cfg_post (cfg_post),
    .expire_o (expire_w)
  );

  wdpm_action u_action (
    .clk      (clk),
    .por_n    (por_n),
    .expire   (expire_w),
    .in_sleep (in_sleep),
    .in_idle  (in_idle),
    .clr      (clr_w),
    .rst_o    (rst_o),
    .nmi_o    (nmi_o),
    .flags_o  (flags_w)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[BIT_EN]  = en_w;
    rd_data[BIT_TMO] = flags_w[2];
    rd_data[BIT_SLP] = flags_w[1];
    rd_data[BIT_IDL] = flags_w[0];
  end

endmodule

// File: rtl/wdpm_chk.sv
module wdpm_chk #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_i,
  input logic             in_sleep,
  input logic             in_idle,
  input logic             wr_en,
  input logic [1:0]       wr_op,
  input logic [REG_W-1:0] rd_data,
  input logic             rst_o,
  input logic             nmi_o,
  input logic             en_w,
  input logic             expire_w
);

  // R1: reset request is a single-cycle pulse
  assert_rst_pulse_R1: assert property (@(posedge clk) disable iff (!por_n)
    rst_o |=> !rst_o);

  // R1: reset request only follows an expiry while awake
  assert_rst_awake_R1: assert property (@(posedge clk) disable iff (!por_n)
    rst_o |-> $past(expire_w && !in_sleep && !in_idle));

  // R2: never both actions at once
  assert_one_action_R2: assert property (@(posedge clk) disable iff (!por_n)
    !(rst_o && nmi_o));

  // R2: power-save expiry leaves the enable set
  assert_nmi_keeps_en_R2: assert property (@(posedge clk) disable iff (!por_n)
    (expire_w && (in_sleep || in_idle) && !sys_rst_i && !wr_en) |=> rd_data[15]);

  // R3: any action is accompanied by the time-out flag
  assert_tmo_flag_R3: assert property (@(posedge clk) disable iff (!por_n)
    (rst_o || nmi_o) |-> rd_data[4]);

  // R4: time-out flag only falls on a clear-alias write
  assert_tmo_sticky_R4: assert property (@(posedge clk) disable iff (!por_n)
    (rd_data[4] && !(wr_en && wr_op == 2'd2)) |=> rd_data[4]);

  // R6: service bit never reads back as 1
  assert_svc_reads0_R6: assert property (@(posedge clk) disable iff (!por_n)
    !rd_data[0]);

  // R8: no expiry while disabled
  assert_no_expire_off_R8: assert property (@(posedge clk) disable iff (!por_n)
    !en_w |-> !expire_w);

  // R9: chip reset clears the enable
  assert_sysrst_clears_R9: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_i |=> !rd_data[15]);

endmodule

bind wdog_pm_top wdpm_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .sys_rst_i (sys_rst_i),
  .in_sleep  (in_sleep),
  .in_idle   (in_idle),
  .wr_en     (wr_en),
  .wr_op     (wr_op),
  .rd_data   (rd_data),
  .rst_o     (rst_o),
  .nmi_o     (nmi_o),
  .en_w      (en_w),
  .expire_w  (expire_w)
);

// File: tb/wdog_pm_top_tb.sv
`timescale 1ns/1ps
module wdog_pm_top_tb;

  localparam int BASE = 4;
  localparam int PMAX = 4;
  localparam int PW   = $clog2(PMAX + 1);

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          sys_rst = 1'b0;
  logic          tick_en = 1'b1;
  logic [PW-1:0] cfg_post = 1;
  logic          in_sleep = 1'b0;
  logic          in_idle = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_op = 2'd0;
  logic [15:0]   wr_data = 16'h0;
  logic [15:0]   rd_data;
  logic          rst_o, nmi_o;

  always #10 clk = ~clk;

  wdog_pm_top #(.BASE_TICKS(BASE), .POST_MAX(PMAX), .REG_W(16)) u_dut (
    .clk(clk), .por_n(por_n), .sys_rst_i(sys_rst), .tick_en(tick_en),
    .cfg_post(cfg_post), .in_sleep(in_sleep), .in_idle(in_idle),
    .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data),
    .rd_data(rd_data), .rst_o(rst_o), .nmi_o(nmi_o)
  );

  int vectors = 0, miscompares = 0;
  int cyc_n = 0, tick_div = 1;
  int rst_pulses = 0, nmi_pulses = 0;
  bit done = 0;

  // behavioural reference model
  bit m_en = 0, m_tmo = 0, m_slp = 0, m_idl = 0, m_rst = 0, m_nmi = 0;
  bit m_svc, m_fire;
  int m_ticks = 0;

  function automatic int total_ticks();
    int e = (int'(cfg_post) > PMAX) ? PMAX : int'(cfg_post);
    return BASE * (1 << e);
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_en = 0; m_ticks = 0; m_tmo = 0; m_slp = 0; m_idl = 0; m_rst = 0; m_nmi = 0;
    end else begin
      m_fire = 0;
      m_svc = wr_en && (wr_op == 2'd0 || wr_op == 2'd1) && wr_data[0] && m_en && !sys_rst;
      if (sys_rst) begin
        m_en = 0; m_ticks = 0;
      end else begin
        if (!m_en || m_svc) m_ticks = 0;
        else if (tick_en) begin
          if (m_ticks + 1 >= total_ticks()) begin m_fire = 1; m_ticks = 0; end
          else m_ticks++;
        end
        if (wr_en) begin
          if (wr_op == 2'd0) m_en = wr_data[15];
          else if (wr_op == 2'd1 && wr_data[15]) m_en = 1;
          else if (wr_op == 2'd2 && wr_data[15]) m_en = 0;
          if (wr_op == 2'd2) begin
            if (wr_data[4]) m_tmo = 0;
            if (wr_data[3]) m_slp = 0;
            if (wr_data[2]) m_idl = 0;
          end
        end
      end
      m_rst = m_fire && !in_sleep && !in_idle;
      m_nmi = m_fire && (in_sleep || in_idle);
      if (m_fire) begin
        m_tmo = 1;
        if (in_sleep) m_slp = 1;
        if (in_idle)  m_idl = 1;
      end
    end
  end

  function automatic logic [15:0] model_rd();
    logic [15:0] v = 16'h0;
    v[15] = m_en; v[4] = m_tmo; v[3] = m_slp; v[2] = m_idl;
    return v;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // one clock: compare at the falling edge, then advance the tick pattern
  task automatic cyc();
    @(negedge clk);
    chk("R1", "rst_o vs model", rst_o, m_rst);
    chk("R2", "nmi_o vs model", nmi_o, m_nmi);
    chk("R5", "rd_data vs model", rd_data, model_rd());
    if (rst_o) rst_pulses++;
    if (nmi_o) nmi_pulses++;
    cyc_n++;
    tick_en = ((cyc_n % tick_div) == 0);
  endtask

  task automatic wr(input logic [1:0] op, input logic [15:0] d);
    wr_en = 1; wr_op = op; wr_data = d;
    cyc();
    wr_en = 0; wr_op = 0; wr_data = 0;
  endtask

  task automatic run_until(input int lim, output int nt, output bit r, output bit n);
    nt = 0; r = 0; n = 0;
    for (int k = 0; k < lim; k++) begin
      if (tick_en) nt++;
      cyc();
      if (rst_o || nmi_o) begin r = rst_o; n = nmi_o; break; end
    end
  endtask

  initial begin
    int nt, extra, rp, np;
    bit r, n;
    repeat (3) cyc();
    chk("R10", "rd_data in reset", rd_data, 0);
    chk("R10", "rst_o in reset", rst_o, 0);
    chk("R10", "nmi_o in reset", nmi_o, 0);
    por_n = 1;
    cyc();

    // awake expiry, e=1 -> 8 ticks
    wr(2'd1, 16'h8000);
    chk("R5", "enable via set alias", rd_data[15], 1);
    run_until(200, nt, r, n);
    chk("R1", "awake expiry gives reset", r, 1);
    chk("R1", "awake expiry no nmi", n, 0);
    chk("R7", "ticks to expiry e=1", nt, 8);
    chk("R3", "flags after awake expiry", rd_data[4:2], 3'b100);
    extra = tick_en;
    cyc();
    chk("R1", "reset pulse one cycle", rst_o, 0);
    run_until(200, nt, r, n);
    chk("R1", "restart gives full period", nt + extra, 8);

    // regular servicing prevents expiry
    rp = rst_pulses;
    for (int i = 0; i < 8; i++) begin
      repeat (4) cyc();
      wr(2'd0, 16'h8001);
    end
    chk("R6", "serviced watchdog no reset", rst_pulses, rp);
    chk("R6", "service bit reads 0", rd_data[0], 0);

    // service in the expiry cycle wins
    wr(2'd0, 16'h8001);
    repeat (7) cyc();
    wr(2'd0, 16'h8001);
    chk("R6", "service on expiry edge cancels", rst_o, 0);
    run_until(200, nt, r, n);
    chk("R6", "period after late service", nt, 8);

    // sleep expiry -> nmi
    wr(2'd2, 16'h001C);
    chk("R4", "clear alias clears flags", rd_data[4:2], 0);
    chk("R5", "clear without bit15 keeps enable", rd_data[15], 1);
    in_sleep = 1;
    wr(2'd0, 16'h8001);
    run_until(200, nt, r, n);
    chk("R2", "sleep expiry gives nmi", n, 1);
    chk("R2", "sleep expiry no reset", r, 0);
    chk("R3", "flags after sleep expiry", rd_data[4:2], 3'b110);
    chk("R2", "enable kept after nmi", rd_data[15], 1);

    // idle expiry
    in_sleep = 0; in_idle = 1;
    wr(2'd2, 16'h001C);
    wr(2'd0, 16'h8001);
    run_until(200, nt, r, n);
    chk("R2", "idle expiry gives nmi", n, 1);
    chk("R3", "flags after idle expiry", rd_data[4:2], 3'b101);
    in_idle = 0;

    // plain and set writes do not touch flags
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'h001C);
    chk("R4", "plain/set writes keep flags", rd_data[4:2], 3'b101);
    chk("R5", "enable after plain write", rd_data[15], 1);

    // chip reset beats a concurrent set, keeps flags
    sys_rst = 1;
    wr(2'd1, 16'h8000);
    sys_rst = 0;
    chk("R9", "sys reset clears enable", rd_data[15], 0);
    chk("R9", "sys reset keeps flags", rd_data[4:2], 3'b101);

    // disabled: nothing happens, service ignored
    rp = rst_pulses; np = nmi_pulses;
    repeat (30) cyc();
    wr(2'd0, 16'h0001);
    repeat (10) cyc();
    chk("R8", "no reset while disabled", rst_pulses, rp);
    chk("R8", "no nmi while disabled", nmi_pulses, np);
    chk("R6", "service while disabled ignored", rd_data[15], 0);
    wr(2'd1, 16'h8000);
    run_until(200, nt, r, n);
    chk("R8", "full period after re-enable", nt, 8);

    // write operation decoding
    wr(2'd2, 16'h8000);
    chk("R5", "clear alias disables", rd_data[15], 0);
    wr(2'd1, 16'h0001);
    chk("R5", "set alias leaves unwritten bit", rd_data[15], 0);
    wr(2'd3, 16'h8000);
    chk("R5", "op 3 ignored", rd_data[15], 0);

    // e=3, sparse ticks -> 32 ticks
    cfg_post = 3; tick_div = 3;
    wr(2'd0, 16'h8001);
    run_until(2000, nt, r, n);
    chk("R7", "ticks to expiry e=3 sparse", nt, 32);

    // exponent above maximum clamps to PMAX=4 -> 64 ticks
    cfg_post = 7; tick_div = 1;
    wr(2'd0, 16'h8001);
    run_until(2000, nt, r, n);
    chk("R7", "clamped exponent", nt, 64);

    // power-on reset clears flags
    por_n = 0;
    cyc();
    chk("R10", "por clears all", rd_data, 0);
    chk("R4", "por clears flags", rd_data[4:2], 0);
    por_n = 1;
    cyc();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule